// File: doc/BRIEF.md
# Counter-Mode Logic Cell with Chained Counter

This block models one programmable logic cell configured as a counter bit, along with a wrapper that chains several such cells into a small up-counter. Each cell holds one register bit and has two 3-input lookup functions. The data function produces the toggled bit, gated by a cascade input. The carry function produces a fast carry toward the next cell. A zeroing gate and a 2-to-1 selector sit after the data function. Together they give a synchronous clear and a synchronous load, and both take precedence over the cascade value.

The register has two asynchronous controls. The first is a group-wide asynchronous control shared by all cells of the wrapper. The second is a chip-wide active-low reset, which overrides everything else. Each cell has a build-time option that marks it as a preset register. When either asynchronous control is applied, a preset-configured cell goes to 1 and any other cell goes to 0.

Each cell drives three outputs: its registered bit, the unregistered output of its data function, and its carry. The wrapper takes one preset mask covering every bit. It chains the carries with the count enable feeding bit 0, and presents the carry of the top bit as the counter's carry-out.

Top module: `cntcell_chain`

## Requirements
- R1: While `rst_chip_n` is 0, every bit of `q` equals the matching `PRESET_MASK` bit (1 for preset-configured bits, 0 otherwise), whatever the other inputs are.
- R2: While `rst_chip_n` is 1 and `grp_async` is 1, every bit of `q` equals its `PRESET_MASK` bit, overriding all synchronous controls.
- R3: With no asynchronous control active, `sclr`=1 at a clock edge makes `q` all zeros, even when `sload`=1 in the same cycle.
- R4: With no asynchronous control active, `sload`=1 and `sclr`=0 at a clock edge loads `load_data` into `q`, whatever the count enable and cascade inputs are.
- R5: With no asynchronous control, no clear and no load, a bit whose `casc_in` bit is 0 is written with 0 at the clock edge. A bit whose `casc_in` bit is 1 takes its counted value.
- R6: With all `casc_in` bits at 1 and no asynchronous control, clear or load, `q` increments by one modulo 2^WIDTH per edge while `cnt_en`=1 and holds while `cnt_en`=0.
- R7: `comb[i]` is the unregistered value (q[i] XOR c[i]) AND casc_in[i], where c[0]=`cnt_en` and c[i]=c[i-1] AND q[i-1]. It does not depend on `sclr`, `sload` or `load_data`.
- R8: `carry_out` equals `cnt_en` AND all bits of `q`. A counting edge taken while `carry_out`=1 wraps `q` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_chip_n | input | 1 | Chip-wide asynchronous reset, active low, highest priority |
| grp_async | input | 1 | Group-wide asynchronous clear (preset for preset-configured bits), active high |
| cnt_en | input | 1 | Count enable, carry-in of bit 0 |
| sload | input | 1 | Synchronous load |
| sclr | input | 1 | Synchronous clear, wins over load |
| load_data | input | WIDTH | Data taken on a synchronous load |
| casc_in | input | WIDTH | Per-bit cascade inputs ANDed into the data function |
| q | output | WIDTH | Registered counter bits |
| comb | output | WIDTH | Unregistered data-function outputs |
| carry_out | output | 1 | Carry from the top bit |

## Verification
The clocked properties assume that both asynchronous controls change only away from the rising clock edge. They also assume that an asynchronous control held across an edge disables any property in flight, so they never judge a cycle in which a reset or group clear lands between two edges. The bench changes every input, the asynchronous ones included, on the falling edge and holds it for a full period. Each pulse on an asynchronous control therefore spans at least one rising edge. Reset and group-clear pulses are kept rare in the random mix so that long counting runs, and carries into the top bit, still occur.

// File: rtl/cntcell_pkg.sv
package cntcell_pkg;

    // Truth masks for the two 3-input lookup functions.
    // Select index is {cascade, carry_in, register}.
    // Data function: (reg XOR carry_in) AND cascade -> indices 5 and 6.
    localparam logic [7:0] LUT_DATA_MASK  = 8'h60;
    // Carry function: carry_in AND reg, cascade ignored -> indices 3 and 7.
    localparam logic [7:0] LUT_CARRY_MASK = 8'h88;

    typedef struct packed {
        logic bit_val;
    } cell_state_t;

    typedef struct packed {
        logic sclr;
        logic sload;
        logic ld_bit;
    } sync_ctrl_t;

endpackage

// File: rtl/cntcell_lut3.sv
module cntcell_lut3 #(
    parameter logic [7:0] MASK = 8'h00
) (
    input  logic       in_a,
    input  logic       in_b,
    input  logic       in_c,
    output logic       lut_out
);
    logic [2:0] sel;

    always_comb begin
        sel     = {in_c, in_b, in_a};
        lut_out = MASK[sel];
    end
endmodule

// File: rtl/cntcell_cell.sv
module cntcell_cell
    import cntcell_pkg::*;
#(
    parameter bit PRESET = 1'b0
) (
    input  logic       clk,
    input  logic       rst_chip_n,
    input  logic       grp_async,
    input  logic       carry_in,
    input  logic       casc,
    input  sync_ctrl_t ctrl,
    output logic       reg_out,
    output logic       lut_out,
    output logic       carry_nx
);
    localparam logic ASYNC_VAL = PRESET;

    cell_state_t state_d, state_q;
    logic        data_lut;
    logic        carry_lut;

    cntcell_lut3 #(.MASK(LUT_DATA_MASK)) u_data_lut (
        .in_a    (state_q.bit_val),
        .in_b    (carry_in),
        .in_c    (casc),
        .lut_out (data_lut)
    );

    cntcell_lut3 #(.MASK(LUT_CARRY_MASK)) u_carry_lut (
        .in_a    (state_q.bit_val),
        .in_b    (carry_in),
        .in_c    (casc),
        .lut_out (carry_lut)
    );

    // Load selector, then clear gate; clear therefore wins over load,
    // and both win over the cascade-gated data value.
    always_comb begin
        logic sel_val;
        sel_val         = ctrl.sload ? ctrl.ld_bit : data_lut;
        state_d.bit_val = sel_val & ~ctrl.sclr;
    end

    always_ff @(posedge clk or negedge rst_chip_n or posedge grp_async) begin
        if (!rst_chip_n) begin
            state_q.bit_val <= ASYNC_VAL;
        end else if (grp_async) begin
            state_q.bit_val <= ASYNC_VAL;
        end else begin
            state_q <= state_d;
        end
    end

    assign reg_out  = state_q.bit_val;
    assign lut_out  = data_lut;
    assign carry_nx = carry_lut;

    // R1: chip-wide reset forces the configured value
    p_chip_reset_r1: assert property (@(posedge clk)
        !rst_chip_n |=> (reg_out == ASYNC_VAL));

    // R2: group asynchronous control forces the configured value
    p_group_async_r2: assert property (@(posedge clk) disable iff (!rst_chip_n)
        grp_async |=> (reg_out == ASYNC_VAL));

    // R3: clear wins over load
    p_sclr_wins_r3: assert property (@(posedge clk) disable iff (!rst_chip_n || grp_async)
        ctrl.sclr |=> (reg_out == 1'b0));

    // R4: load takes the data bit
    p_load_r4: assert property (@(posedge clk) disable iff (!rst_chip_n || grp_async)
        (ctrl.sload && !ctrl.sclr) |=> (reg_out == $past(ctrl.ld_bit)));

    // R5: cascade low zeroes the next value when no load or clear
    p_cascade_r5: assert property (@(posedge clk) disable iff (!rst_chip_n || grp_async)
        (!ctrl.sload && !ctrl.sclr && !casc) |=> (reg_out == 1'b0));

    // R6: no carry with cascade high holds the bit
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_chip_n || grp_async)
        (!ctrl.sload && !ctrl.sclr && casc && !carry_in) |=> $stable(reg_out));
endmodule

// File: rtl/cntcell_chain.sv
module cntcell_chain
    import cntcell_pkg::*;
#(
    parameter int               WIDTH       = 4,
    parameter logic [WIDTH-1:0] PRESET_MASK = '0
) (
    input  logic             clk,
    input  logic             rst_chip_n,
    input  logic             grp_async,
    input  logic             cnt_en,
    input  logic             sload,
    input  logic             sclr,
    input  logic [WIDTH-1:0] load_data,
    input  logic [WIDTH-1:0] casc_in,
    output logic [WIDTH-1:0] q,
    output logic [WIDTH-1:0] comb,
    output logic             carry_out
);
    localparam int CHAIN_LEN = WIDTH + 1;

    logic [CHAIN_LEN-1:0] carry_chain;

    assign carry_chain[0] = cnt_en;

    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_cell
        sync_ctrl_t ctrl_d;

        always_comb begin
            ctrl_d.sclr   = sclr;
            ctrl_d.sload  = sload;
            ctrl_d.ld_bit = load_data[gi];
        end

        cntcell_cell #(.PRESET(PRESET_MASK[gi])) u_cell (
            .clk        (clk),
            .rst_chip_n (rst_chip_n),
            .grp_async  (grp_async),
            .carry_in   (carry_chain[gi]),
            .casc       (casc_in[gi]),
            .ctrl       (ctrl_d),
            .reg_out    (q[gi]),
            .lut_out    (comb[gi]),
            .carry_nx   (carry_chain[gi+1])
        );
    end

    assign carry_out = carry_chain[WIDTH];

    // R6: plain counting increments by one
    p_count_up_r6: assert property (@(posedge clk) disable iff (!rst_chip_n || grp_async)
        (cnt_en && !sclr && !sload && (&casc_in)) |=> (q == WIDTH'($past(q) + 1'b1)));

    // R8: a counting edge with carry out wraps to zero
    p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_chip_n || grp_async)
        (carry_out && !sclr && !sload && (&casc_in)) |=> (q == '0));
endmodule

// File: tb/cntcell_chain_bench.sv
`timescale 1ns/1ps
module cntcell_chain_bench;
    localparam int         W    = 4;
    localparam logic [3:0] PMSK = 4'b1001;

    logic         clk = 1'b0;
    logic         rst_chip_n = 1'b0;
    logic         grp_async = 1'b0;
    logic         cnt_en = 1'b0;
    logic         sload = 1'b0;
    logic         sclr = 1'b0;
    logic [W-1:0] load_data = '0;
    logic [W-1:0] casc_in = '1;
    logic [W-1:0] q;
    logic [W-1:0] comb;
    logic         carry_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [W-1:0] exp_q;

    always #4 clk = ~clk;

    cntcell_chain #(.WIDTH(W), .PRESET_MASK(PMSK)) u_cntcell_chain (
        .clk(clk), .rst_chip_n(rst_chip_n), .grp_async(grp_async),
        .cnt_en(cnt_en), .sload(sload), .sclr(sclr),
        .load_data(load_data), .casc_in(casc_in),
        .q(q), .comb(comb), .carry_out(carry_out)
    );

    function automatic logic [W-1:0] f_comb(logic [W-1:0] qv, logic en, logic [W-1:0] cas);
        logic c;
        logic [W-1:0] r;
        c = en;
        for (int i = 0; i < W; i++) begin
            r[i] = (qv[i] ^ c) & cas[i];
            c    = c & qv[i];
        end
        return r;
    endfunction

    function automatic logic [W-1:0] f_next(logic [W-1:0] qv, logic en, logic sc,
                                            logic sl, logic [W-1:0] ld, logic [W-1:0] cas);
        if (sc) return '0;
        if (sl) return ld;
        return f_comb(qv, en, cas);
    endfunction

    task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, expv, $time);
        end
    endtask

    // One cycle: check registered state, drive new inputs, check combinational
    // outputs, then predict the state after the coming rising edge.
    task automatic cycle(logic rn, logic ac, logic en, logic sl, logic sc,
                         logic [W-1:0] ld, logic [W-1:0] cas, string qtag);
        @(negedge clk);
        check(qtag, q, exp_q);
        rst_chip_n = rn; grp_async = ac; cnt_en = en;
        sload = sl; sclr = sc; load_data = ld; casc_in = cas;
        #1;
        if (!rn || ac) exp_q = PMSK;
        check("R7", comb, f_comb(exp_q, en, cas));
        check("R8", {{(W-1){1'b0}}, carry_out}, {{(W-1){1'b0}}, en & (&exp_q)});
        if (rn && !ac) exp_q = f_next(exp_q, en, sc, sl, ld, cas);
    endtask

    function automatic string f_tag(logic rn, logic ac, logic sl, logic sc, logic [W-1:0] cas);
        if (!rn) return "R1";
        if (ac)  return "R2";
        if (sc)  return "R3";
        if (sl)  return "R4";
        if (cas != '1) return "R5";
        return "R6";
    endfunction

    initial begin
        string tg;
        exp_q = PMSK;
        // reset state, with busy sync inputs: R1
        cycle(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'b0110, 4'hF, "R1");
        cycle(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'b0110, 4'hF, "R1");
        // count up through wrap: R6, R8
        cycle(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 4'hF, "R1");
        for (int k = 0; k < 20; k++)
            cycle(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 4'hF, "R6");
        // hold with enable low: R6
        cycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 4'hF, "R6");
        // clear and load together, clear wins: R3
        cycle(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'hA, 4'h0, "R6");
        // load with cascade low, load wins: R4, R5
        cycle(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 4'hE, 4'h0, "R3");
        // cascade low on some bits: R5
        cycle(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 4'b1010, "R4");
        // group asynchronous control over a load: R2
        cycle(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 4'h6, 4'hF, "R5");
        // load all ones then count into wrap: R8
        cycle(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'hF, 4'hF, "R2");
        cycle(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 4'hF, "R4");
        tg = "R8";
        // constrained random mix
        for (int k = 0; k < 3000; k++) begin
            logic rn, ac, en, sl, sc;
            logic [W-1:0] ld, cas;
            rn  = ($urandom % 40) != 0;
            ac  = ($urandom % 40) == 0;
            en  = ($urandom % 4) != 0;
            sl  = ($urandom % 10) == 0;
            sc  = ($urandom % 14) == 0;
            ld  = W'($urandom);
            cas = (($urandom % 5) == 0) ? W'($urandom) : '1;
            cycle(rn, ac, en, sl, sc, ld, cas, tg);
            tg = f_tag(rn, ac, sl, sc, cas);
        end
        @(negedge clk);
        check(tg, q, exp_q);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule